// File: doc/BRIEF.md
# USB OUT Endpoint Packet Buffer

This block is the receive-side buffer of one non-control OUT endpoint in a USB device function controller. A packet engine, which has already done bit-level decoding, CRC checking and unstuffing, hands it each OUT data packet: a start strobe with the toggle bit of the data PID, a stream of valid bytes, and a closing strobe that says whether the packet ended good or with an error. The block decides whether to store the packet and which handshake to return (ACK, NAK, STALL or none). It also tracks the expected data toggle. Stored packets sit in a byte FIFO that the CPU drains through a read port.

The FIFO holds one or two packets. Which one depends on the programmed maximum packet size (MAXP): a MAXP that fits twice in the FIFO gives double buffering. A control/status register carries the mode and stall bits, the sticky error flags and the packet-ready flag. CPU writes to that register release packets. A separate command pulse flushes the oldest packet.

The receive controller has three states. IDLE waits for a start strobe. A packet that may be stored moves IDLE to TAKE. A packet that must be refused (stall, no free slot, wrong toggle) moves IDLE to SKIP, and the handshake decided at the start is held there. TAKE returns to IDLE on either end strobe, and it commits or discards the packet at that point. SKIP returns to IDLE on either end strobe, and it emits the held handshake only on a good end.

Top module: `usb_out_ep_buf`

## Requirements
- R1: After reset every register bit reads 0: csr_rdata is 0 and maxp_rdata is 0. No handshake is issued.
- R2: If MAXP is greater than half the FIFO size (32 bytes by default), the buffer has one packet slot; otherwise it has two. An OUT packet that arrives with no free slot gets a NAK, and the stored FIFO data is left unchanged.
- R3: For a non-isochronous packet that ends good, rx_pid_odd (0 = DATA0, 1 = DATA1) is compared with the expected toggle. On a match the packet is stored and ACKed, and the expected toggle flips. On a mismatch the packet is ACKed and dropped, and the packet-ready flag is left unchanged.
- R4: Packet-ready (csr bit 4) reads 1 while at least one packet is stored. The CPU releases the oldest packet by writing 0 to bit 4; writing 1 there has no effect. fifo_rdata shows the oldest packet's next byte, and each fifo_rd pulse advances it by one.
- R5: A cmd_flush pulse empties the FIFO when it holds one packet. When it holds two, the pulse discards only the older packet, and the newer one stays readable.
- R6: With auto-clear (csr bit 2) set, a packet is released by itself once MAXP bytes of it have been read.
- R7: A packet longer than MAXP is discarded, sets force-stall (csr bit 6) and gets a STALL. While bit 6 is set, every non-isochronous OUT gets a STALL. Writing 0 to bit 6 clears it.
- R8: While send-stall (csr bit 1) is set by the CPU, every non-isochronous OUT gets a STALL and is not stored.
- R9: A packet that ends with rx_end_err is discarded. It gets no handshake and leaves the toggle unchanged. The next packet is stored where the discarded one would have been.
- R10: With isochronous mode (csr bit 0) set, no toggle check is made and no handshake is issued. An error end sets data-error (csr bit 7), which stays set on a write of 1 and clears on a write of 0.
- R11: Overrun (csr bit 5) is set by an isochronous packet that finds no free slot, and by a packet whose bytes exceed the FIFO size. A CPU write of 1 leaves it set; a write of 0 clears it.
- R12: Writing 1 and then 0 to toggle-init (csr bit 3) makes the next accepted non-isochronous packet a DATA0 packet.
- R13: A handshake is a one-cycle hs_vld pulse in the cycle after rx_end_ok, with hs_code 01 = ACK, 10 = NAK, 11 = STALL. No handshake follows rx_end_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start | input | 1 | Start of an OUT data packet |
| rx_pid_odd | input | 1 | Toggle bit of the data PID, valid with rx_start |
| rx_byte_vld | input | 1 | rx_byte carries a payload byte |
| rx_byte | input | 8 | Payload byte |
| rx_end_ok | input | 1 | Packet ended with good CRC |
| rx_end_err | input | 1 | Packet ended with a CRC or stuffing error |
| hs_vld | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| csr_wr | input | 1 | Write strobe of the control/status register |
| csr_wdata | input | 8 | Control/status write data |
| csr_rdata | output | 8 | Control/status read value |
| maxp_wr | input | 1 | Write strobe of the MAXP register |
| maxp_wdata | input | MAXP_W | MAXP write data |
| maxp_rdata | output | MAXP_W | MAXP read value |
| cmd_flush | input | 1 | Flush command pulse |
| fifo_rd | input | 1 | Pop one byte of the oldest packet |
| fifo_rdata | output | 8 | Byte at the head of the oldest packet |

## Verification
Packets are sent with a matching toggle, with a mismatched toggle, and with an error end, so the test can tell storing apart from silent dropping and from full discard with pointer rewind. Packets are also sent into a full buffer in dual mode and in single mode, which shows that the slot count follows MAXP. A packet one byte longer than MAXP exercises the stall path. A run with two stored packets, followed by a flush, separates discarding the older packet from emptying the FIFO. Isochronous traffic is sent last, to show that the handshake is suppressed and that the overrun and data-error flags stay set on a write of 1 and clear only on a write of 0.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_TAKE = 2'd1,
        RX_SKIP = 2'd2
    } rx_st_e;

    localparam int B_ISO   = 0;
    localparam int B_SSTL  = 1;
    localparam int B_AUTO  = 2;
    localparam int B_TINIT = 3;
    localparam int B_PRDY  = 4;
    localparam int B_OVR   = 5;
    localparam int B_FSTL  = 6;
    localparam int B_DERR  = 7;

endpackage

// File: rtl/ob_rx_fsm.sv
module ob_rx_fsm
    import usb_out_ep_pkg::*;
#(
    parameter int FIFO_BYTES = 64,
    parameter int MAXP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_pid_odd,
    input  logic              rx_byte_vld,
    input  logic              rx_end_ok,
    input  logic              rx_end_err,
    input  logic              iso,
    input  logic              stall_any,
    input  logic              slot_free,
    input  logic              exp_tog,
    input  logic [MAXP_W-1:0] maxp,
    output logic              wr_en,
    output logic              commit,
    output logic              abort,
    output logic [MAXP_W-1:0] pkt_len,
    output logic              set_force,
    output logic              set_derr,
    output logic              set_ovr,
    output logic              tog_flip,
    output logic              hs_vld,
    output logic [1:0]        hs_code
);
    localparam logic [MAXP_W:0] CAP = (MAXP_W+1)'(FIFO_BYTES);

    rx_st_e state, nxt;
    hs_e    pend, pend_n, hs_n;
    logic [MAXP_W-1:0] wcnt;
    logic big, ovf;
    logic too_long, no_room;

    assign too_long = (wcnt >= maxp);
    assign no_room  = ({1'b0, wcnt} >= CAP);
    assign pkt_len  = wcnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // next state and per-cycle actions
    always_comb begin
        nxt       = state;
        pend_n    = pend;
        hs_n      = HS_NONE;
        wr_en     = 1'b0;
        commit    = 1'b0;
        abort     = 1'b0;
        set_force = 1'b0;
        set_derr  = 1'b0;
        set_ovr   = 1'b0;
        tog_flip  = 1'b0;
        unique case (state)
            RX_IDLE: begin
                if (rx_start) begin
                    if (stall_any && !iso) begin
                        nxt    = RX_SKIP;
                        pend_n = HS_STALL;
                    end else if (!slot_free) begin
                        nxt     = RX_SKIP;
                        pend_n  = iso ? HS_NONE : HS_NAK;
                        set_ovr = iso;
                    end else if (!iso && (rx_pid_odd != exp_tog)) begin
                        nxt    = RX_SKIP;
                        pend_n = HS_ACK;
                    end else begin
                        nxt = RX_TAKE;
                    end
                end
            end
            RX_TAKE: begin
                wr_en = rx_byte_vld && !big && !ovf && !too_long && !no_room;
                if (rx_end_err) begin
                    nxt      = RX_IDLE;
                    abort    = 1'b1;
                    set_derr = iso;
                end else if (rx_end_ok) begin
                    nxt = RX_IDLE;
                    if (big) begin
                        abort     = 1'b1;
                        set_force = 1'b1;
                        hs_n      = iso ? HS_NONE : HS_STALL;
                    end else if (ovf) begin
                        abort   = 1'b1;
                        set_ovr = 1'b1;
                        hs_n    = iso ? HS_NONE : HS_NAK;
                    end else begin
                        commit   = 1'b1;
                        tog_flip = !iso;
                        hs_n     = iso ? HS_NONE : HS_ACK;
                    end
                end
            end
            RX_SKIP: begin
                if (rx_end_err) begin
                    nxt      = RX_IDLE;
                    set_derr = iso;
                end else if (rx_end_ok) begin
                    nxt  = RX_IDLE;
                    hs_n = pend;
                end
            end
            default: nxt = RX_IDLE;
        endcase
    end

    // registered outputs and packet bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= HS_NONE;
            wcnt    <= '0;
            big     <= 1'b0;
            ovf     <= 1'b0;
            hs_vld  <= 1'b0;
            hs_code <= HS_NONE;
        end else begin
            pend    <= pend_n;
            hs_vld  <= (hs_n != HS_NONE);
            hs_code <= hs_n;
            if (state != RX_TAKE) begin
                wcnt <= '0;
                big  <= 1'b0;
                ovf  <= 1'b0;
            end else if (rx_byte_vld) begin
                if (too_long)     big  <= 1'b1;
                else if (no_room) ovf  <= 1'b1;
                if (wr_en)        wcnt <= wcnt + 1'b1;
            end
        end
    end

    // R13
    handshake_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_vld |-> $past(rx_end_ok));

endmodule

// File: rtl/ob_store.sv
module ob_store #(
    parameter int FIFO_BYTES = 64,
    parameter int MAXP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              commit,
    input  logic              abort,
    input  logic [MAXP_W-1:0] pkt_len,
    input  logic              rd_en,
    input  logic              release_req,
    input  logic              auto_en,
    input  logic [MAXP_W-1:0] maxp,
    output logic [7:0]        fifo_rdata,
    output logic [1:0]        pkt_cnt,
    output logic              slot_free
);
    localparam int AW = $clog2(FIFO_BYTES);
    localparam logic [MAXP_W-1:0] HALF = MAXP_W'(FIFO_BYTES / 2);

    logic [7:0]        mem [FIFO_BYTES];
    logic [AW-1:0]     wr_ptr, wr_base, rd_ptr, rd_base;
    logic [MAXP_W-1:0] rd_cnt;
    logic [MAXP_W-1:0] len_q [2];
    logic [1:0]        cnt;
    logic single, rd_go, auto_hit, rel;

    assign single     = (maxp > HALF);
    assign slot_free  = single ? (cnt == 2'd0) : (cnt < 2'd2);
    assign rd_go      = rd_en && (cnt != 2'd0);
    assign auto_hit   = auto_en && rd_go && ((rd_cnt + 1'b1) == maxp);
    assign rel        = (release_req || auto_hit) && (cnt != 2'd0);
    assign fifo_rdata = mem[rd_ptr];
    assign pkt_cnt    = cnt;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // write side: open packet pointer rewinds on abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wr_base <= '0;
        end else begin
            if (abort)      wr_ptr <= wr_base;
            else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (commit)     wr_base <= wr_ptr;
        end
    end

    // read side and packet length queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            rd_base  <= '0;
            rd_cnt   <= '0;
            cnt      <= '0;
            len_q[0] <= '0;
            len_q[1] <= '0;
        end else begin
            if (rel) begin
                rd_base <= rd_base + len_q[0][AW-1:0];
                rd_ptr  <= rd_base + len_q[0][AW-1:0];
                rd_cnt  <= '0;
            end else if (rd_go) begin
                rd_ptr <= rd_ptr + 1'b1;
                rd_cnt <= rd_cnt + 1'b1;
            end
            unique case ({commit, rel})
                2'b01: begin
                    len_q[0] <= len_q[1];
                    cnt      <= cnt - 1'b1;
                end
                2'b10: begin
                    len_q[cnt[0]] <= pkt_len;
                    cnt           <= cnt + 1'b1;
                end
                2'b11: begin
                    if (cnt == 2'd1) begin
                        len_q[0] <= pkt_len;
                    end else begin
                        len_q[0] <= len_q[1];
                        len_q[1] <= pkt_len;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 2'd2);

    // R4
    rd_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt == 2'd0 && !commit) |=> $stable(rd_ptr));

endmodule

// File: rtl/ob_csr.sv
module ob_csr
    import usb_out_ep_pkg::*;
#(
    parameter int MAXP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [7:0]        csr_wdata,
    input  logic              maxp_wr,
    input  logic [MAXP_W-1:0] maxp_wdata,
    input  logic              cmd_flush,
    input  logic              pkt_rdy,
    input  logic              set_force,
    input  logic              set_derr,
    input  logic              set_ovr,
    input  logic              tog_flip,
    output logic [7:0]        csr_rdata,
    output logic [MAXP_W-1:0] maxp,
    output logic              iso,
    output logic              stall_any,
    output logic              auto_en,
    output logic              exp_tog,
    output logic              release_req
);
    logic send_stall, tog_init, ovr, fstall, derr;
    logic clr_ovr, clr_fstall, clr_derr;

    assign clr_ovr     = csr_wr && !csr_wdata[B_OVR];
    assign clr_fstall  = csr_wr && !csr_wdata[B_FSTL];
    assign clr_derr    = csr_wr && !csr_wdata[B_DERR];
    assign release_req = (csr_wr && !csr_wdata[B_PRDY]) || cmd_flush;
    assign stall_any   = send_stall || fstall;

    always_comb begin
        csr_rdata          = '0;
        csr_rdata[B_ISO]   = iso;
        csr_rdata[B_SSTL]  = send_stall;
        csr_rdata[B_AUTO]  = auto_en;
        csr_rdata[B_TINIT] = tog_init;
        csr_rdata[B_PRDY]  = pkt_rdy;
        csr_rdata[B_OVR]   = ovr;
        csr_rdata[B_FSTL]  = fstall;
        csr_rdata[B_DERR]  = derr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iso        <= 1'b0;
            send_stall <= 1'b0;
            auto_en    <= 1'b0;
            tog_init   <= 1'b0;
            ovr        <= 1'b0;
            fstall     <= 1'b0;
            derr       <= 1'b0;
            exp_tog    <= 1'b0;
            maxp       <= '0;
        end else begin
            if (csr_wr) begin
                iso        <= csr_wdata[B_ISO];
                send_stall <= csr_wdata[B_SSTL];
                auto_en    <= csr_wdata[B_AUTO];
                tog_init   <= csr_wdata[B_TINIT];
            end
            if (maxp_wr) maxp <= maxp_wdata;
            ovr    <= set_ovr   || (ovr    && !clr_ovr);
            fstall <= set_force || (fstall && !clr_fstall);
            derr   <= set_derr  || (derr   && !clr_derr);
            if (tog_init)      exp_tog <= 1'b0;
            else if (tog_flip) exp_tog <= !exp_tog;
        end
    end

    // R11
    ovr_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr) |-> $past(csr_wr && !csr_wdata[B_OVR]));

    // R12
    toggle_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tog_init |=> !exp_tog);

endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf
    import usb_out_ep_pkg::*;
#(
    parameter int FIFO_BYTES = 64,
    parameter int MAXP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic              rx_pid_odd,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_end_ok,
    input  logic              rx_end_err,
    output logic              hs_vld,
    output logic [1:0]        hs_code,
    input  logic              csr_wr,
    input  logic [7:0]        csr_wdata,
    output logic [7:0]        csr_rdata,
    input  logic              maxp_wr,
    input  logic [MAXP_W-1:0] maxp_wdata,
    output logic [MAXP_W-1:0] maxp_rdata,
    input  logic              cmd_flush,
    input  logic              fifo_rd,
    output logic [7:0]        fifo_rdata
);
    logic              wr_en, commit, abort, set_force, set_derr, set_ovr, tog_flip;
    logic              iso, stall_any, auto_en, exp_tog, release_req, slot_free, pkt_rdy;
    logic [MAXP_W-1:0] maxp, pkt_len;
    logic [1:0]        pkt_cnt;

    assign pkt_rdy    = (pkt_cnt != 2'd0);
    assign maxp_rdata = maxp;

    ob_rx_fsm #(.FIFO_BYTES(FIFO_BYTES), .MAXP_W(MAXP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rx_start(rx_start), .rx_pid_odd(rx_pid_odd), .rx_byte_vld(rx_byte_vld),
        .rx_end_ok(rx_end_ok), .rx_end_err(rx_end_err),
        .iso(iso), .stall_any(stall_any), .slot_free(slot_free), .exp_tog(exp_tog),
        .maxp(maxp), .wr_en(wr_en), .commit(commit), .abort(abort), .pkt_len(pkt_len),
        .set_force(set_force), .set_derr(set_derr), .set_ovr(set_ovr),
        .tog_flip(tog_flip), .hs_vld(hs_vld), .hs_code(hs_code)
    );

    ob_store #(.FIFO_BYTES(FIFO_BYTES), .MAXP_W(MAXP_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(rx_byte), .commit(commit), .abort(abort),
        .pkt_len(pkt_len), .rd_en(fifo_rd), .release_req(release_req),
        .auto_en(auto_en), .maxp(maxp), .fifo_rdata(fifo_rdata),
        .pkt_cnt(pkt_cnt), .slot_free(slot_free)
    );

    ob_csr #(.MAXP_W(MAXP_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .maxp_wr(maxp_wr), .maxp_wdata(maxp_wdata),
        .cmd_flush(cmd_flush), .pkt_rdy(pkt_rdy),
        .set_force(set_force), .set_derr(set_derr), .set_ovr(set_ovr), .tog_flip(tog_flip),
        .csr_rdata(csr_rdata), .maxp(maxp), .iso(iso), .stall_any(stall_any),
        .auto_en(auto_en), .exp_tog(exp_tog), .release_req(release_req)
    );

    // R3
    ready_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pkt_rdy) && !$past(iso)) |-> (hs_vld && hs_code == HS_ACK));

endmodule

// File: tb/test_usb_out_ep_buf.sv
module test_usb_out_ep_buf;
    localparam logic [1:0] ACK = 2'b01, NAK = 2'b10, STL = 2'b11, NONE = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_start = 0, rx_pid_odd = 0, rx_byte_vld = 0, rx_end_ok = 0, rx_end_err = 0;
    logic [7:0] rx_byte = '0;
    logic hs_vld;
    logic [1:0] hs_code;
    logic csr_wr = 0;
    logic [7:0] csr_wdata = '0, csr_rdata;
    logic maxp_wr = 0;
    logic [7:0] maxp_wdata = '0, maxp_rdata;
    logic cmd_flush = 0, fifo_rd = 0;
    logic [7:0] fifo_rdata;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    usb_out_ep_buf i_usb_out_ep_buf (
        .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_pid_odd(rx_pid_odd),
        .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_end_ok(rx_end_ok),
        .rx_end_err(rx_end_err), .hs_vld(hs_vld), .hs_code(hs_code),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .maxp_wr(maxp_wr), .maxp_wdata(maxp_wdata), .maxp_rdata(maxp_rdata),
        .cmd_flush(cmd_flush), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every handshake pulse
    always @(negedge clk) begin
        if (rst_n && hs_vld) begin
            if (exp_q.size() == 0) begin
                chk({30'd0, hs_code}, {30'd0, NONE}, "R13 unexpected handshake");
            end else begin
                chk({30'd0, hs_code}, {30'd0, exp_q.pop_front()}, tag_q.pop_front());
            end
        end
    end

    // driver: one packet, expected handshake pushed first
    task automatic send(input bit odd, input int n, input logic [7:0] seed,
                        input bit err, input logic [1:0] exp_hs, input string tag);
        if (exp_hs != NONE) begin
            exp_q.push_back(exp_hs);
            tag_q.push_back(tag);
        end
        @(negedge clk); rx_start = 1; rx_pid_odd = odd;
        @(negedge clk); rx_start = 0;
        for (int i = 0; i < n; i++) begin
            rx_byte_vld = 1; rx_byte = 8'(seed + i);
            @(negedge clk);
        end
        rx_byte_vld = 0;
        if (err) rx_end_err = 1; else rx_end_ok = 1;
        @(negedge clk); rx_end_ok = 0; rx_end_err = 0;
        @(negedge clk);
    endtask

    task automatic wcsr(input logic [7:0] v);
        @(negedge clk); csr_wr = 1; csr_wdata = v;
        @(negedge clk); csr_wr = 0;
    endtask

    task automatic wmaxp(input logic [7:0] v);
        @(negedge clk); maxp_wr = 1; maxp_wdata = v;
        @(negedge clk); maxp_wr = 0;
    endtask

    task automatic flush();
        @(negedge clk); cmd_flush = 1;
        @(negedge clk); cmd_flush = 0;
    endtask

    task automatic rd_pkt(input int n, input logic [7:0] seed, input string tag);
        for (int i = 0; i < n; i++) begin
            chk({24'd0, fifo_rdata}, {24'd0, 8'(seed + i)}, tag);
            fifo_rd = 1;
            @(negedge clk);
            fifo_rd = 0;
        end
    endtask

    task automatic bit_chk(input int b, input bit v, input string tag);
        chk({31'd0, csr_rdata[b]}, {31'd0, v}, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R13 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({24'd0, csr_rdata}, 32'd0, "R1 csr reset");
        chk({24'd0, maxp_rdata}, 32'd0, "R1 maxp reset");
        chk({31'd0, hs_vld}, 32'd0, "R1 no handshake");

        // dual mode, toggle sequence, full buffer
        wmaxp(8'd16);
        chk({24'd0, maxp_rdata}, 32'd16, "R2 maxp readback");
        send(0, 8, 8'h10, 0, ACK, "R3 DATA0 ack");
        bit_chk(4, 1, "R4 ready after store");
        send(1, 4, 8'h40, 0, ACK, "R3 DATA1 ack");
        send(0, 3, 8'h55, 0, NAK, "R2 dual full nak");
        rd_pkt(8, 8'h10, "R2 data kept after nak");
        wcsr(8'h10);
        bit_chk(4, 1, "R4 write 1 keeps ready");
        wcsr(8'h00);
        bit_chk(4, 1, "R4 second packet still ready");
        rd_pkt(4, 8'h40, "R4 second packet data");
        wcsr(8'h00);
        bit_chk(4, 0, "R4 released all");

        // wrong toggle dropped
        send(1, 2, 8'h33, 0, ACK, "R3 mismatch acked");
        bit_chk(4, 0, "R3 mismatch dropped");

        // flush one then two
        send(0, 5, 8'h50, 0, ACK, "R3 store for flush");
        flush();
        bit_chk(4, 0, "R5 flush single empties");
        send(1, 6, 8'h60, 0, ACK, "R5 older");
        send(0, 7, 8'h70, 0, ACK, "R5 newer");
        flush();
        bit_chk(4, 1, "R5 newer kept");
        rd_pkt(7, 8'h70, "R5 newer data");
        wcsr(8'h00);

        // error end
        send(1, 3, 8'h90, 1, NONE, "R9 error");
        bit_chk(4, 0, "R9 error discarded");
        send(1, 2, 8'hA0, 0, ACK, "R9 toggle unchanged");
        rd_pkt(2, 8'hA0, "R9 rewind data");
        wcsr(8'h00);

        // auto clear
        wcsr(8'h04);
        send(0, 16, 8'hB0, 0, ACK, "R6 full packet");
        rd_pkt(15, 8'hB0, "R6 data");
        bit_chk(4, 1, "R6 not yet released");
        rd_pkt(1, 8'hBF, "R6 last byte");
        bit_chk(4, 0, "R6 auto released");

        // oversize force stall
        send(1, 17, 8'hC0, 0, STL, "R7 oversize stall");
        bit_chk(6, 1, "R7 force flag set");
        bit_chk(4, 0, "R7 oversize discarded");
        send(0, 2, 8'hC8, 0, STL, "R7 stalled while set");
        wcsr(8'h44);
        bit_chk(6, 1, "R7 write 1 keeps flag");
        wcsr(8'h04);
        bit_chk(6, 0, "R7 cleared by 0");
        send(1, 2, 8'hD0, 0, ACK, "R7 after clear");
        wcsr(8'h04);

        // send stall
        wcsr(8'h06);
        send(0, 2, 8'hD4, 0, STL, "R8 send stall");
        bit_chk(4, 0, "R8 not stored");
        wcsr(8'h04);

        // toggle init
        send(0, 1, 8'hE0, 0, ACK, "R12 before init");
        wcsr(8'h04);
        wcsr(8'h0C);
        wcsr(8'h04);
        send(1, 1, 8'hE1, 0, ACK, "R12 DATA1 after init");
        bit_chk(4, 0, "R12 DATA1 dropped");
        send(0, 1, 8'hE2, 0, ACK, "R12 DATA0 after init");
        bit_chk(4, 1, "R12 DATA0 stored");
        wcsr(8'h00);

        // single mode
        wmaxp(8'd40);
        send(1, 10, 8'h20, 0, ACK, "R2 single store");
        send(0, 3, 8'h77, 0, NAK, "R2 single full nak");
        rd_pkt(10, 8'h20, "R2 single data");
        wcsr(8'h00);

        // isochronous
        wcsr(8'h01);
        send(1, 5, 8'h80, 0, NONE, "R10 iso");
        bit_chk(4, 1, "R10 iso stored no toggle check");
        send(0, 3, 8'h88, 0, NONE, "R11 iso no slot");
        bit_chk(5, 1, "R11 overrun set");
        wcsr(8'h31);
        bit_chk(5, 1, "R11 write 1 keeps overrun");
        wcsr(8'h11);
        bit_chk(5, 0, "R11 write 0 clears overrun");
        rd_pkt(5, 8'h80, "R10 iso data");
        wcsr(8'h01);
        send(0, 2, 8'h99, 1, NONE, "R10 iso error");
        bit_chk(7, 1, "R10 data error set");
        bit_chk(4, 0, "R10 error packet discarded");
        wcsr(8'h81);
        bit_chk(7, 1, "R10 write 1 keeps data error");
        wcsr(8'h01);
        bit_chk(7, 0, "R10 write 0 clears data error");

        repeat (3) @(negedge clk);
        chk(exp_q.size(), 32'd0, "R13 missing handshakes");
        done = 1;
        summary();
        $finish;
    end
endmodule